// File: doc/BRIEF.md
# DMA Stream Control and Transfer Counter

This block keeps the control state of a single DMA stream. Software programs it through a small register port: a control word with the run bit, a loop selector and two interrupt enables, a 16-bit transfer count, a 32-bit peripheral address, and a status word of sticky error flags. A separate transfer engine reports each finished data beat and any error. The block answers with a single output that tells the engine whether it may issue another request.

While the stream runs, the count and the address are frozen against software writes. Each reported beat lowers the count by one. When a non-looping stream reaches zero it stops by itself and emits a one-cycle completion pulse. A looping stream instead reloads the value software last programmed and keeps running. Turning the stream on again from the stopped state also reloads that saved value. A bus error or a FIFO-threshold mismatch stops the stream at once. A direct-mode error only raises its flag.

Top module: `dma_stream_ctrl`

## Requirements
- R1: After reset all four registers read 0, and `req_ok`, `irq` and `tc_pulse` are 0. The register offsets are: control 0, count 1, address 2, status 3.
- R2: Writes to the count (offset 1) and to the address (offset 2) take effect only while the run bit is 0. While the stream runs they are dropped, and reads return the live count and the held address.
- R3: While the stream runs with a non-zero count, each cycle with `xfer_done` high lowers the count by one. With a count of zero, `xfer_done` leaves it unchanged.
- R4: In non-loop mode, the beat that takes the count from 1 to 0 clears the run bit. `tc_pulse` is then high for exactly the following cycle.
- R5: In loop mode (control bit 1), the beat that ends the block reloads the saved count and leaves the run bit set. `tc_pulse` is raised in the same way as in R4.
- R6: Writing control with bit 0 set while the stream is stopped starts it and reloads the count with the last value written to offset 1.
- R7: `req_ok` is high exactly when the run bit (control bit 0) is 1 and the count is non-zero.
- R8: `bus_err` clears the run bit on the next edge and sets the sticky transfer-error flag, status bit 0. This takes priority over a software write in the same cycle.
- R9: `fifo_err` clears the run bit on the next edge and sets the sticky FIFO flag, status bit 2.
- R10: `dm_err` sets the sticky direct-mode flag, status bit 1, and does not change the run bit.
- R11: `irq` = (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3). Writing 1 to a status bit clears that flag. Both enables reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write register offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read register offset |
| reg_rdata | output | 32 | Read data (combinational) |
| xfer_done | input | 1 | One data beat completed |
| bus_err | input | 1 | Bus transfer error from the engine |
| dm_err | input | 1 | Direct-mode error from the engine |
| fifo_err | input | 1 | FIFO threshold does not fit the burst size |
| req_ok | output | 1 | Engine may issue a request |
| tc_pulse | output | 1 | One-cycle end-of-block pulse |
| irq | output | 1 | Combined error interrupt |

## Verification
A corrupted count shows on the very next read of offset 1, and also on `req_ok` as soon as it wrongly reaches or leaves zero. A lost or stale saved count shows only at the next loop wrap or restart, which the bench forces right after each block. A run bit that fails to drop after an error or at the end of a block shows on the next cycle as `req_ok` staying high and bit 0 of the control read staying set. A flag or enable stuck at the wrong value shows on `irq` in the cycle after the write that exposes it.

// File: rtl/dma_stream_pkg.sv
// Shared register offsets and the control word layout for the stream controller.
package dma_stream_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_PADDR = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    // Control word, LSB first: run, loop, transfer-error ie, direct-mode ie
    typedef struct packed {
        logic dme_ie;
        logic te_ie;
        logic loop;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned NFLAG  = 3;   // te, dme, fifo
    localparam int unsigned NIRQ   = 2;   // flags with an interrupt enable
endpackage

// File: rtl/dma_stream_cfg.sv
// Control word and peripheral address storage.
// Assumes: hw_stop overrides any software write to the run bit in the same cycle.
// The address is held while the run bit is set.
module dma_stream_cfg
    import dma_stream_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  ctrl_t             ctrl_wdata,
    input  logic              paddr_we,
    input  logic [ADDR_W-1:0] paddr_wdata,
    input  logic              hw_stop,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] paddr_q,
    output logic              start
);
    // Start: software sets run while stopped, and no hardware stop is pending
    assign start = ctrl_we && ctrl_wdata.run && !ctrl_q.run && !hw_stop;

    // Control register with a hardware clear of the run bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_wdata;
            if (hw_stop) ctrl_q.run <= 1'b0;
        end
    end

    // Peripheral address, writable only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                      paddr_q <= '0;
        else if (paddr_we && !ctrl_q.run) paddr_q <= paddr_wdata;
    end
endmodule

// File: rtl/dma_stream_counter.sv
// Transfer counter with a saved reload value.
// Assumes: load_we and start are never both high (they come from different offsets).
module dma_stream_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             loop,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q,
    output logic             last_stop,
    output logic             tc_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] shadow_q;
    logic             step_ok;
    logic             last;

    // A beat counts only while running with beats left
    assign step_ok   = step && run && (cnt_q != '0);
    assign last      = step_ok && (cnt_q == ONE);
    assign last_stop = last && !loop;

    // Saved value and live count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            cnt_q    <= '0;
        end else if (load_we && !run) begin
            shadow_q <= load_val;
            cnt_q    <= load_val;
        end else if (start) begin
            cnt_q <= shadow_q;
        end else if (step_ok) begin
            cnt_q <= (last && loop) ? shadow_q : cnt_q - ONE;
        end
    end

    // End-of-block pulse, one cycle after the final beat
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= last;
    end
endmodule

// File: rtl/dma_stream_flags.sv
// Sticky error flags with write-one-to-clear and the masked interrupt.
// Assumes: a set and a clear in the same cycle leave the flag set.
module dma_stream_flags #(
    parameter int unsigned NF = 3,
    parameter int unsigned NI = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NI-1:0] ie,
    output logic [NF-1:0] flag_q,
    output logic          irq
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        // One sticky flag
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= set[i] | (flag_q[i] & ~clr[i]);
        end
    end

    // Interrupt from the flags that carry an enable
    assign irq = |(flag_q[NI-1:0] & ie);
endmodule

// File: rtl/dma_stream_ctrl.sv
// Top of the stream controller: register decode, read mux and glue.
// Assumes: reads are combinational on reg_raddr, and writes take effect at the edge.
module dma_stream_ctrl
    import dma_stream_pkg::*;
#(
    parameter int unsigned BUS_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    input  logic [1:0]       reg_raddr,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             xfer_done,
    input  logic             bus_err,
    input  logic             dm_err,
    input  logic             fifo_err,
    output logic             req_ok,
    output logic             tc_pulse,
    output logic             irq
);
    ctrl_t            ctrl_q;
    logic [BUS_W-1:0] paddr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NFLAG-1:0] flag_q;
    logic             start;
    logic             last_stop;
    logic             hw_stop;
    logic             run;
    logic             loop;

    assign run     = ctrl_q.run;
    assign loop    = ctrl_q.loop;
    assign hw_stop = last_stop || bus_err || fifo_err;
    assign req_ok  = run && (cnt_q != '0);

    dma_stream_cfg #(.ADDR_W(BUS_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (reg_we && (reg_addr == REG_CTRL)),
        .ctrl_wdata (ctrl_t'(reg_wdata[CTRL_W-1:0])),
        .paddr_we   (reg_we && (reg_addr == REG_PADDR)),
        .paddr_wdata(reg_wdata),
        .hw_stop    (hw_stop),
        .ctrl_q     (ctrl_q),
        .paddr_q    (paddr_q),
        .start      (start)
    );

    dma_stream_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .loop     (loop),
        .load_we  (reg_we && (reg_addr == REG_COUNT)),
        .load_val (reg_wdata[CNT_W-1:0]),
        .start    (start),
        .step     (xfer_done),
        .cnt_q    (cnt_q),
        .last_stop(last_stop),
        .tc_q     (tc_pulse)
    );

    dma_stream_flags #(.NF(NFLAG), .NI(NIRQ)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({fifo_err, dm_err, bus_err}),
        .clr   ((reg_we && (reg_addr == REG_STAT)) ? reg_wdata[NFLAG-1:0] : '0),
        .ie    ({ctrl_q.dme_ie, ctrl_q.te_ie}),
        .flag_q(flag_q),
        .irq   (irq)
    );

    // Read mux over the four registers
    always_comb begin
        unique case (reg_raddr)
            REG_CTRL:  reg_rdata = BUS_W'(ctrl_q);
            REG_COUNT: reg_rdata = BUS_W'(cnt_q);
            REG_PADDR: reg_rdata = paddr_q;
            default:   reg_rdata = BUS_W'(flag_q);
        endcase
    end
endmodule

// File: rtl/dma_stream_ctrl_chk.sv
// Property checker for the stream controller, attached by bind.
module dma_stream_ctrl_chk #(
    parameter int unsigned BUS_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             loop,
    input logic [CNT_W-1:0] cnt,
    input logic [BUS_W-1:0] paddr,
    input logic             te_flag,
    input logic             xfer_done,
    input logic             bus_err,
    input logic             fifo_err,
    input logic             reg_we,
    input logic             req_ok,
    input logic             tc_pulse
);
    AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(xfer_done)) |-> $stable(cnt)); // R2
    AST_PADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(paddr)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(xfer_done) && ($past(cnt) > CNT_W'(1)))
            |-> (cnt == $past(cnt) - CNT_W'(1))); // R3
    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(xfer_done)); // R4
    AST_LOOP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && $past(run) && $past(loop) && !$past(bus_err)
            && !$past(fifo_err) && !$past(reg_we)) |-> run); // R5
    AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !req_ok); // R7
    AST_BUS_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !run); // R8
    AST_TE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> te_flag); // R8
    AST_FIFO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err |=> !run); // R9
endmodule

bind dma_stream_ctrl dma_stream_ctrl_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .loop     (loop),
    .cnt      (cnt_q),
    .paddr    (paddr_q),
    .te_flag  (flag_q[0]),
    .xfer_done(xfer_done),
    .bus_err  (bus_err),
    .fifo_err (fifo_err),
    .reg_we   (reg_we),
    .req_ok   (req_ok),
    .tc_pulse (tc_pulse)
);

// File: tb/dma_stream_ctrl_tb.sv
// Scoreboard bench: the driver queues expected values, the monitor samples and compares.
module dma_stream_ctrl_tb;
    localparam int K_REG = 0, K_REQ = 1, K_IRQ = 2, K_TC = 3;

    typedef struct {
        int          kind;
        logic [1:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        xfer_done = 1'b0, bus_err = 1'b0, dm_err = 1'b0, fifo_err = 1'b0;
    logic        req_ok, tc_pulse, irq;

    int    n_chk = 0;
    int    n_err = 0;
    bit    ended = 1'b0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    dma_stream_ctrl u_dut (.*);

    // Write one register at the next edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    // Pulse one engine input for one cycle (0 done, 1 bus, 2 dm, 3 fifo)
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: xfer_done = 1'b1;
            1: bus_err   = 1'b1;
            2: dm_err    = 1'b1;
            default: fifo_err = 1'b1;
        endcase
        @(posedge clk); #1;
        xfer_done = 1'b0; bus_err = 1'b0; dm_err = 1'b0; fifo_err = 1'b0;
    endtask

    // Queue one expectation and wait until the monitor has taken it
    task automatic expect_v(input int kind, input logic [1:0] a,
                            input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: sample at the falling edge, compare with the queued item
    initial begin
        forever begin
            item_t       it;
            logic [31:0] act;
            wait (sb_q.size() > 0);
            @(negedge clk);
            it = sb_q.pop_front();
            reg_raddr = it.addr;
            #1;
            case (it.kind)
                K_REG:   act = reg_rdata;
                K_REQ:   act = {31'b0, req_ok};
                K_IRQ:   act = {31'b0, irq};
                default: act = {31'b0, tc_pulse};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s kind %0d addr %0d: actual %h expected %h",
                         it.tag, it.kind, it.addr, act, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        if (!ended) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        expect_v(K_REG, 2'd0, 32'h0, "R1 ctrl");
        expect_v(K_REG, 2'd1, 32'h0, "R1 count");
        expect_v(K_REG, 2'd2, 32'h0, "R1 paddr");
        expect_v(K_REG, 2'd3, 32'h0, "R1 status");
        expect_v(K_REQ, 2'd0, 32'h0, "R1 req_ok");
        expect_v(K_IRQ, 2'd0, 32'h0, "R1 irq");
        expect_v(K_TC,  2'd0, 32'h0, "R1 tc");

        // Program and start, non-loop
        wr(2'd1, 32'd3);
        wr(2'd2, 32'h4000_1000);
        wr(2'd0, 32'h1);
        expect_v(K_REG, 2'd1, 32'd3, "R6 start count");
        expect_v(K_REQ, 2'd0, 32'h1, "R7 req while running");

        // R2 locked fields
        wr(2'd1, 32'd9);
        wr(2'd2, 32'h0000_DEAD);
        expect_v(K_REG, 2'd1, 32'd3, "R2 count locked");
        expect_v(K_REG, 2'd2, 32'h4000_1000, "R2 paddr locked");

        // R3 / R4 countdown and end of block
        pulse(0);
        expect_v(K_REG, 2'd1, 32'd2, "R3 first beat");
        pulse(0);
        expect_v(K_REG, 2'd1, 32'd1, "R3 second beat");
        pulse(0);
        expect_v(K_TC,  2'd0, 32'h1, "R4 tc high");
        expect_v(K_TC,  2'd0, 32'h0, "R4 tc one cycle");
        expect_v(K_REG, 2'd1, 32'd0, "R4 count rests at 0");
        expect_v(K_REG, 2'd0, 32'h0, "R4 run cleared");
        expect_v(K_REQ, 2'd0, 32'h0, "R7 req after end");

        // R6 restart reloads the saved value
        wr(2'd0, 32'h1);
        expect_v(K_REG, 2'd1, 32'd3, "R6 reload on restart");
        expect_v(K_REQ, 2'd0, 32'h1, "R7 req after restart");

        // R5 loop mode (run already set: no reload)
        wr(2'd0, 32'h3);
        expect_v(K_REG, 2'd1, 32'd3, "R6 no reload when already running");
        pulse(0);
        pulse(0);
        expect_v(K_REG, 2'd1, 32'd1, "R5 count before wrap");
        pulse(0);
        expect_v(K_TC,  2'd0, 32'h1, "R5 tc on wrap");
        expect_v(K_REG, 2'd1, 32'd3, "R5 reload on wrap");
        expect_v(K_REG, 2'd0, 32'h3, "R5 run kept");

        // R8 bus error, R11 interrupt gating and clear
        pulse(1);
        expect_v(K_REG, 2'd0, 32'h2, "R8 run cleared by bus_err");
        expect_v(K_REG, 2'd3, 32'h1, "R8 te flag");
        expect_v(K_IRQ, 2'd0, 32'h0, "R11 irq masked");
        wr(2'd0, 32'h4);
        expect_v(K_IRQ, 2'd0, 32'h1, "R11 irq enabled");
        wr(2'd3, 32'h1);
        expect_v(K_REG, 2'd3, 32'h0, "R11 te flag cleared");
        expect_v(K_IRQ, 2'd0, 32'h0, "R11 irq after clear");

        // R2 unlocked when stopped, R9 fifo error
        wr(2'd1, 32'd5);
        expect_v(K_REG, 2'd1, 32'd5, "R2 count writable when stopped");
        wr(2'd2, 32'h0000_BEEF);
        expect_v(K_REG, 2'd2, 32'h0000_BEEF, "R2 paddr writable when stopped");
        wr(2'd0, 32'h1);
        expect_v(K_REQ, 2'd0, 32'h1, "R7 req before fifo error");
        pulse(3);
        expect_v(K_REG, 2'd0, 32'h0, "R9 run cleared by fifo_err");
        expect_v(K_REG, 2'd3, 32'h4, "R9 fifo flag");
        wr(2'd3, 32'h4);

        // R10 direct-mode error keeps running
        wr(2'd0, 32'h9);
        pulse(2);
        expect_v(K_REG, 2'd0, 32'h9, "R10 run unchanged");
        expect_v(K_REG, 2'd3, 32'h2, "R10 dme flag");
        expect_v(K_IRQ, 2'd0, 32'h1, "R11 dme irq");
        wr(2'd3, 32'h2);
        expect_v(K_IRQ, 2'd0, 32'h0, "R11 dme irq cleared");

        // R7 / R3 zero count: no request, beats ignored
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h1);
        expect_v(K_REQ, 2'd0, 32'h0, "R7 no req at zero");
        pulse(0);
        expect_v(K_REG, 2'd1, 32'd0, "R3 beat ignored at zero");
        expect_v(K_REG, 2'd0, 32'h1, "R7 run stays at zero count");

        ended = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule